// File: doc/BRIEF.md
# Oversampled Serial Receiver with Early Stop Re-arm

This block receives asynchronous serial characters from a single input line. It looks at the line only on the cycles where a sixteen-times-bit-rate tick is present. Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. In the default triple-sample variant, the receiver reads every bit at sub-bit positions 7, 8 and 9 of sixteen and takes the majority of the three values. It raises a noise flag when any of those triples in the frame did not agree.

The receiver does not wait for the whole stop bit to pass. It finishes the stop bit as soon as the last sample of that bit has been taken. It then searches for the next start edge from sub-bit position 10, or from position 9 when a single centre sample is used. This means a sender whose clock runs a little fast can drop whole sixteenths from its stop bits, and it can keep streaming without losing characters. The decoded character leaves the block with a one-cycle valid strobe, together with framing-error and noise indications for that character. Baud generation, buffering, parity and transmit belong to other blocks.

Top module: `ssrx_top`

## Requirements
- R1: After reset, `dataValid`, `frameErr` and `noiseErr` are low and `dataOut` is zero. While the line stays high, no character is reported.
- R2: A frame consists of one low start bit, then DATA_BITS data bits with the least significant first, then one high stop bit. The data bits appear on `dataOut` together with `dataValid` high for one cycle. `dataOut` changes only in that cycle.
- R3: In triple-sample mode (VOTE3=1), each bit's value is the majority of the line at sub-bit positions 7, 8 and 9 out of 16. A single sample that disagrees with the other two does not change the decoded bit.
- R4: `noiseErr` is high in the `dataValid` cycle when any bit of the frame (start, data or stop) had three samples that did not all agree. `noiseErr` is never high without `dataValid`.
- R5: A falling edge whose start-bit majority vote is high is treated as a glitch. It produces no output, and the receiver returns to searching for a start edge.
- R6: If the stop-bit vote is low, `frameErr` is high in the `dataValid` cycle. A further frame is accepted only after the line has been seen high again. `frameErr` is never high without `dataValid`.
- R7: In triple-sample mode, the start-edge search resumes at sub-bit position 10 of the stop bit. Back-to-back frames whose stop bits last only 10 or 12 sixteenths are all received correctly, with the sub-bit count realigned to each new start edge.
- R8: In single-sample mode (VOTE3=0), each bit is taken from sub-bit position 8 alone and the search resumes at position 9. Back-to-back frames with 9-sixteenth stop bits are received correctly.
- R9: `dataValid` lasts exactly one cycle and follows a cycle in which the baud tick was present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baudTick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| dataOut | output | DATA_BITS | Last received character |
| dataValid | output | 1 | One-cycle strobe for a new character |
| frameErr | output | 1 | Stop-bit vote was low, valid with dataValid |
| noiseErr | output | 1 | Some bit's samples disagreed, valid with dataValid |

## Verification
The hardest condition to reach is a line transition at an exact sub-bit position. Examples are a single sixteenth flipped at the centre of one data bit, or a new start edge arriving at the very sixteenth where the search re-arms. To reach these, the bench produces the baud tick itself. It changes the line right after each tick, so every value it drives is seen by exactly one tick after the two-flop synchronizer. This lets the stimulus be written as a list of sixteenths per bit, with the stop bit cut to 9, 10 or 12 sixteenths. A second receiver in single-sample mode shares the same line for the shortest-stop stream.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
  typedef struct packed {
    logic clearFrame;
    logic takeSample;
    logic checkStart;
    logic shiftData;
    logic finish;
  } rxStrobes_t;
endpackage

// File: rtl/ssrx_datapath.sv
module ssrx_datapath
  import ssrx_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter bit VOTE3     = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 baudTick,
  input  logic                 rxLine,
  input  rxStrobes_t           stb,
  output logic                 lineNow,
  output logic                 linePrev,
  output logic                 voteNow,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 dataValid,
  output logic                 frameErr,
  output logic                 noiseErr
);
  logic rxMeta, rxSync;
  logic disagree;
  logic noiseAcc;
  logic [DATA_BITS-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxMeta   <= 1'b1;
      rxSync   <= 1'b1;
      linePrev <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
      if (baudTick) linePrev <= rxSync;
    end
  end

  assign lineNow = rxSync;

  generate
    if (VOTE3) begin : g_triple
      logic [1:0] smp;
      always_ff @(posedge clk) begin
        if (rst) smp <= 2'b11;
        else if (stb.takeSample) smp <= {smp[0], rxSync};
      end
      assign voteNow  = (smp[1] & smp[0]) | (smp[1] & rxSync) | (smp[0] & rxSync);
      assign disagree = !((smp[1] == smp[0]) && (smp[0] == rxSync));
    end else begin : g_single
      assign voteNow  = rxSync;
      assign disagree = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg  <= '0;
      noiseAcc  <= 1'b0;
      dataOut   <= '0;
      dataValid <= 1'b0;
      frameErr  <= 1'b0;
      noiseErr  <= 1'b0;
    end else begin
      dataValid <= 1'b0;
      frameErr  <= 1'b0;
      noiseErr  <= 1'b0;
      if (stb.clearFrame) noiseAcc <= 1'b0;
      if (stb.checkStart || stb.shiftData) noiseAcc <= noiseAcc | disagree;
      if (stb.shiftData) shiftReg <= {voteNow, shiftReg[DATA_BITS-1:1]};
      if (stb.finish) begin
        dataOut   <= shiftReg;
        dataValid <= 1'b1;
        frameErr  <= ~voteNow;
        noiseErr  <= noiseAcc | disagree;
      end
    end
  end
endmodule

// File: rtl/ssrx_ctrl.sv
module ssrx_ctrl
  import ssrx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8,
  parameter bit VOTE3      = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baudTick,
  input  logic       lineNow,
  input  logic       linePrev,
  input  logic       voteNow,
  output rxStrobes_t stb
);
  localparam int SUB_W   = $clog2(OVERSAMPLE);
  localparam int BIDX_W  = $clog2(DATA_BITS + 2);
  localparam int MID     = OVERSAMPLE / 2;
  localparam int FIRST   = VOTE3 ? MID - 1 : MID;
  localparam int LAST    = VOTE3 ? MID + 1 : MID;
  localparam logic [SUB_W-1:0]  SUB_FIRST = SUB_W'(FIRST);
  localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(LAST);
  localparam logic [SUB_W-1:0]  SUB_END   = SUB_W'(OVERSAMPLE - 1);
  localparam logic [BIDX_W-1:0] IDX_LASTD = BIDX_W'(DATA_BITS);

  typedef enum logic {HUNT, FRAME} rxState_e;

  rxState_e          state, stateNext;
  logic [SUB_W-1:0]  subCnt, subNext;
  logic [BIDX_W-1:0] bitIdx, bitNext;
  logic              fallEdge;

  assign fallEdge = baudTick & linePrev & ~lineNow;

  always_comb begin
    stb       = '0;
    stateNext = state;
    subNext   = subCnt;
    bitNext   = bitIdx;
    case (state)
      HUNT: begin
        if (fallEdge) begin
          stb.clearFrame = 1'b1;
          subNext        = SUB_W'(1);
          bitNext        = '0;
          stateNext      = FRAME;
        end
      end
      default: begin
        if (baudTick) begin
          stb.takeSample = (subCnt >= SUB_FIRST) && (subCnt <= SUB_LAST);
          if (subCnt == SUB_LAST) begin
            if (bitIdx == '0) begin
              if (voteNow) stateNext = HUNT;
              else stb.checkStart = 1'b1;
            end else if (bitIdx <= IDX_LASTD) begin
              stb.shiftData = 1'b1;
            end else begin
              stb.finish = 1'b1;
              stateNext  = HUNT;
            end
          end
          if (subCnt == SUB_END) begin
            subNext = '0;
            bitNext = bitIdx + BIDX_W'(1);
          end else begin
            subNext = subCnt + SUB_W'(1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= HUNT;
      subCnt <= '0;
      bitIdx <= '0;
    end else begin
      state  <= stateNext;
      subCnt <= subNext;
      bitIdx <= bitNext;
    end
  end
endmodule

// File: rtl/ssrx_top.sv
module ssrx_top
  import ssrx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8,
  parameter bit VOTE3      = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 baudTick,
  input  logic                 rxLine,
  output logic [DATA_BITS-1:0] dataOut,
  output logic                 dataValid,
  output logic                 frameErr,
  output logic                 noiseErr
);
  rxStrobes_t stb;
  logic lineNow, linePrev, voteNow;

  ssrx_ctrl #(.OVERSAMPLE(OVERSAMPLE), .DATA_BITS(DATA_BITS), .VOTE3(VOTE3)) ctrl_i (
    .clk(clk), .rst(rst), .baudTick(baudTick),
    .lineNow(lineNow), .linePrev(linePrev), .voteNow(voteNow), .stb(stb)
  );

  ssrx_datapath #(.DATA_BITS(DATA_BITS), .VOTE3(VOTE3)) dp_i (
    .clk(clk), .rst(rst), .baudTick(baudTick), .rxLine(rxLine), .stb(stb),
    .lineNow(lineNow), .linePrev(linePrev), .voteNow(voteNow),
    .dataOut(dataOut), .dataValid(dataValid), .frameErr(frameErr), .noiseErr(noiseErr)
  );
endmodule

// File: rtl/ssrx_chk.sv
module ssrx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 baudTick,
  input logic [DATA_BITS-1:0] dataOut,
  input logic                 dataValid,
  input logic                 frameErr,
  input logic                 noiseErr
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (!dataValid && !frameErr && !noiseErr && dataOut == '0));

  a_r2_data_held: assert property (@(posedge clk) disable iff (rst)
    !dataValid |-> $stable(dataOut));

  a_r4_noise_with_valid: assert property (@(posedge clk) disable iff (rst)
    noiseErr |-> dataValid);

  a_r6_fe_with_valid: assert property (@(posedge clk) disable iff (rst)
    frameErr |-> dataValid);

  a_r9_valid_single_cycle: assert property (@(posedge clk) disable iff (rst)
    dataValid |=> !dataValid);

  a_r9_valid_after_tick: assert property (@(posedge clk) disable iff (rst)
    dataValid |-> $past(baudTick));
endmodule

bind ssrx_top ssrx_chk #(.DATA_BITS(DATA_BITS)) chk_i (
  .clk(clk), .rst(rst), .baudTick(baudTick), .dataOut(dataOut),
  .dataValid(dataValid), .frameErr(frameErr), .noiseErr(noiseErr)
);

// File: tb/ssrx_top_tb_top.sv
module ssrx_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic baudTick = 1'b0;
  logic rxLine = 1'b1;
  int   divCnt = 0;

  logic [7:0] dOut, sOut;
  logic dValid, dFe, dNoise, sValid, sFe, sNoise;

  int checks = 0;
  int errors = 0;

  logic [7:0] tRx[16];
  logic       tFe[16];
  logic       tNz[16];
  int         tCount = 0;
  logic [7:0] sRx[16];
  int         sCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    divCnt   <= (divCnt == TICK_DIV - 1) ? 0 : divCnt + 1;
    baudTick <= (divCnt == TICK_DIV - 1);
  end

  ssrx_top #(.VOTE3(1'b1)) dut_i (
    .clk(clk), .rst(rst), .baudTick(baudTick), .rxLine(rxLine),
    .dataOut(dOut), .dataValid(dValid), .frameErr(dFe), .noiseErr(dNoise)
  );

  ssrx_top #(.VOTE3(1'b0)) dutSingle_i (
    .clk(clk), .rst(rst), .baudTick(baudTick), .rxLine(rxLine),
    .dataOut(sOut), .dataValid(sValid), .frameErr(sFe), .noiseErr(sNoise)
  );

  always @(negedge clk) begin
    if (!rst && dValid) begin
      if (tCount < 16) begin
        tRx[tCount] = dOut; tFe[tCount] = dFe; tNz[tCount] = dNoise;
      end
      tCount++;
    end
    if (!rst && sValid) begin
      if (sCount < 16) sRx[sCount] = sOut;
      sCount++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitTick();
    @(posedge clk);
    while (baudTick !== 1'b1) @(posedge clk);
  endtask

  task automatic driveFor(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      rxLine <= v;
      waitTick();
    end
  endtask

  // flipBit: -1 none, 0 start, 1..8 data, 9 stop; flipPos: sub-bit position to invert
  task automatic sendFrame(input logic [7:0] val, input int stopLen, input logic stopVal,
                           input int flipBit, input int flipPos);
    for (int b = 0; b < 10; b++) begin
      logic v;
      int   len;
      v   = (b == 0) ? 1'b0 : (b == 9) ? stopVal : val[b-1];
      len = (b == 9) ? stopLen : 16;
      for (int t = 0; t < len; t++) begin
        rxLine <= (b == flipBit && t == flipPos) ? ~v : v;
        waitTick();
      end
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(dOut == 8'h00 && !dValid && !dFe && !dNoise, "R1 reset outputs",
          {dOut, dValid, dFe, dNoise}, 0);
    driveFor(1'b1, 40);
    @(negedge clk);
    check(tCount == 0, "R1 idle line gives no character", tCount, 0);
  endtask

  task automatic testBasic();
    int base = tCount;
    sendFrame(8'hA6, 16, 1'b1, -1, 0);
    driveFor(1'b1, 4);
    check(tCount == base + 1, "R2 one character", tCount - base, 1);
    check(tRx[base] == 8'hA6, "R2 LSB-first data", tRx[base], 8'hA6);
    check(!tFe[base] && !tNz[base], "R2 clean flags", {tFe[base], tNz[base]}, 0);
  endtask

  task automatic testNoise();
    int base = tCount;
    sendFrame(8'hA5, 16, 1'b1, 3, 8);
    driveFor(1'b1, 4);
    check(tRx[base] == 8'hA5, "R3 centre flip outvoted", tRx[base], 8'hA5);
    check(tNz[base] == 1'b1, "R4 noise on centre flip", tNz[base], 1);
    sendFrame(8'h5A, 16, 1'b1, 1, 7);
    driveFor(1'b1, 4);
    check(tRx[base+1] == 8'h5A, "R3 early flip outvoted", tRx[base+1], 8'h5A);
    check(tNz[base+1] == 1'b1 && !tFe[base+1], "R4 noise on early flip", tNz[base+1], 1);
    sendFrame(8'h5A, 16, 1'b1, 1, 6);
    driveFor(1'b1, 4);
    check(tNz[base+2] == 1'b0, "R4 flip outside window ignored", tNz[base+2], 0);
  endtask

  task automatic testGlitch();
    int base = tCount;
    driveFor(1'b0, 4);
    driveFor(1'b1, 30);
    check(tCount == base, "R5 glitch gives no character", tCount - base, 0);
    sendFrame(8'h3C, 16, 1'b1, -1, 0);
    driveFor(1'b1, 4);
    check(tCount == base + 1 && tRx[base] == 8'h3C, "R5 frame after glitch", tRx[base], 8'h3C);
  endtask

  task automatic testFraming();
    int base = tCount;
    sendFrame(8'h81, 16, 1'b0, -1, 0);
    driveFor(1'b0, 20);
    check(tCount == base + 1 && tFe[base] == 1'b1, "R6 framing error", tFe[base], 1);
    check(tRx[base] == 8'h81, "R6 data with framing error", tRx[base], 8'h81);
    check(tCount == base + 1, "R6 held-low line starts no frame", tCount - base, 1);
    driveFor(1'b1, 6);
    sendFrame(8'h42, 16, 1'b1, -1, 0);
    driveFor(1'b1, 4);
    check(tCount == base + 2 && tRx[base+1] == 8'h42 && !tFe[base+1],
          "R6 recovery after high", tRx[base+1], 8'h42);
  endtask

  task automatic testShortStop();
    logic [7:0] vals[5] = '{8'h3C, 8'h81, 8'hFF, 8'h00, 8'hC7};
    int base = tCount;
    for (int i = 0; i < 5; i++) sendFrame(vals[i], (i % 2 == 0) ? 10 : 12, 1'b1, -1, 0);
    driveFor(1'b1, 6);
    check(tCount == base + 5, "R7 all short-stop frames received", tCount - base, 5);
    for (int i = 0; i < 5; i++)
      check(tRx[base+i] == vals[i] && !tFe[base+i] && !tNz[base+i],
            "R7 short-stop data", tRx[base+i], vals[i]);
  endtask

  task automatic testSingle();
    logic [7:0] vals[4] = '{8'h96, 8'h01, 8'h80, 8'h6B};
    int base;
    driveFor(1'b1, 200);
    base = sCount;
    for (int i = 0; i < 4; i++) sendFrame(vals[i], 9, 1'b1, -1, 0);
    driveFor(1'b1, 6);
    check(sCount == base + 4, "R8 single-sample stream count", sCount - base, 4);
    for (int i = 0; i < 4; i++)
      check(sRx[base+i] == vals[i], "R8 single-sample data", sRx[base+i], vals[i]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    rst <= 1'b0;
    testReset();
    testBasic();
    testNoise();
    testGlitch();
    testFraming();
    tCount = 0;
    testShortStop();
    testSingle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule